// File: doc/BRIEF.md
# Interrupt Collector with Handler Registers

This block sits next to a small processor core and gathers interrupt requests from 32 lines. Each line can be raised by the bit of a 32-bit external request vector that has the same index. Three internal event strobes share the lowest lines: a timer tick, a fault event (breakpoint or illegal instruction) and a misaligned-access bus error. Requests are held in a sticky pending set. A mask register decides which pending lines may cause an entry.

When the core reports an instruction boundary and at least one unmasked line is pending, the block raises a take strobe. At that clock edge it moves into handler mode and stores two values: the core's current program counter, as the return address, and a bitmask of every unmasked pending line. A single handler entry may therefore have to service several lines. Those lines leave the pending set in the same edge. While the handler runs, new requests only accumulate. A return strobe from the core ends handler mode. Four 32-bit handler registers can be read and written by the core; two of them are plain scratch storage.

A build parameter removes the whole controller. With it cleared, no entry is ever taken.

Top module: `irq_collector`

## Requirements
- R1: External request bit i raises line i. Internal events are ORed onto fixed lines: timer onto line 0, fault onto line 1, misaligned-access error onto line 2.
- R2: A request seen in any cycle stays pending until an entry captures it, even if its source drops in the next cycle.
- R3: Mask bit i set to 1 disables line i from causing an entry. A mask write replaces all 32 bits at once. The mask resets to all ones.
- R4: irq_take is high in a cycle exactly when the controller is built in, not in handler mode, core_ready is high and some unmasked line is pending.
- R5: At an entry edge, handler register 0 is loaded with core_pc.
- R6: At an entry edge, handler register 1 is loaded with the bitmask of all pending lines whose mask bit is 0.
- R7: Lines captured at an entry are cleared from pending in that edge. A request asserted in the entry cycle, including one on a captured line, remains pending. Masked pending lines are kept.
- R8: While in_handler is high, irq_take stays low and requests keep accumulating in pending.
- R9: handler_ret while in handler mode clears in_handler at the next edge, so an entry can follow in the next cycle. handler_ret outside handler mode has no effect.
- R10: The core can write any handler register through the write port. Registers 2 and 3 hold what was last written. If a core write to register 0 or 1 arrives in an entry cycle, the entry capture wins.
- R11: hreg_rdata shows the register selected by hreg_ridx in the same cycle: 0 return address, 1 serviced mask, 2 and 3 scratch.
- R12: After reset, pending is empty, in_handler is low and all four handler registers read zero.
- R13: With ENABLE set to 0, irq_take and in_handler stay low and handler register reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | 32 | External request, one bit per line |
| evt_timer | input | 1 | Internal timer event, line 0 |
| evt_fault | input | 1 | Breakpoint or illegal instruction event, line 1 |
| evt_misalign | input | 1 | Misaligned-access bus error, line 2 |
| core_pc | input | 32 | Current program counter, stored as the return address |
| core_ready | input | 1 | Core is at a point where an entry may occur |
| handler_ret | input | 1 | Core leaves the handler |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | New mask value, 1 = line disabled |
| hreg_we | input | 1 | Handler register write strobe |
| hreg_widx | input | 2 | Handler register write index |
| hreg_wdata | input | 32 | Handler register write data |
| hreg_ridx | input | 2 | Handler register read index |
| hreg_rdata | output | 32 | Selected handler register |
| irq_take | output | 1 | Entry happens at the coming edge |
| in_handler | output | 1 | Handler mode is active |

## Verification
The bench targets a request that is asserted again in the cycle its line is captured. A design that cleared pending after merging new requests would lose it and never re-enter after the return. It checks that an internal event, pulsed for one cycle while masked, still causes an entry once the mask opens. A non-sticky design would never take it. It drives a core write to the return-address register in the entry cycle, where the wrong priority would leave the written value in place of core_pc. Long random runs mix returns outside handler mode and mask writes during entries. These expose a design that nests entries, computes the cause from the new mask, or leaves handler mode without a return.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned IRQ_LINES  = 32;
    localparam int unsigned XLEN       = 32;
    localparam int unsigned HREG_COUNT = 4;
    localparam int unsigned HREG_IDX_W = $clog2(HREG_COUNT);

    localparam int unsigned LINE_TIMER    = 0;
    localparam int unsigned LINE_FAULT    = 1;
    localparam int unsigned LINE_MISALIGN = 2;

    typedef enum logic [HREG_IDX_W-1:0] {
        HR_RETADDR  = 2'd0,
        HR_CAUSE    = 2'd1,
        HR_SCRATCH0 = 2'd2,
        HR_SCRATCH1 = 2'd3
    } hreg_sel_e;

    typedef enum logic {
        SEQ_IDLE    = 1'b0,
        SEQ_HANDLER = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic timer;
        logic fault;
        logic misalign;
    } int_evt_t;

    typedef struct packed {
        logic                 fire;
        logic [XLEN-1:0]      ret_pc;
        logic [IRQ_LINES-1:0] cause;
    } entry_t;

    function automatic logic [IRQ_LINES-1:0] merge_requests(
        input logic [IRQ_LINES-1:0] ext,
        input int_evt_t             ev
    );
        logic [IRQ_LINES-1:0] r;
        r = ext;
        r[LINE_TIMER]    = r[LINE_TIMER]    | ev.timer;
        r[LINE_FAULT]    = r[LINE_FAULT]    | ev.fault;
        r[LINE_MISALIGN] = r[LINE_MISALIGN] | ev.misalign;
        return r;
    endfunction

endpackage

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int unsigned LINES = IRQ_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] req_i,
    input  logic [LINES-1:0] clr_i,
    output logic [LINES-1:0] pending_o
);

    logic [LINES-1:0] pend_q;

    // Clear captured lines first, then merge this cycle's requests,
    // so that a request arriving in an entry cycle is never lost.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | req_i;
        end
    end

    assign pending_o = pend_q;

    // R2 and R7: every request of the previous cycle is pending now
    assert_req_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (req_i != '0) |=> ((pending_o & $past(req_i)) == $past(req_i)));

    // R7: pending lines that were not captured survive the edge
    assert_uncaptured_kept_R7: assert property (@(posedge clk) disable iff (rst)
        ((pending_o & ~clr_i) != '0) |=>
            ((pending_o & $past(pending_o & ~clr_i)) == $past(pending_o & ~clr_i)));

endmodule

// File: rtl/irqc_sequencer.sv
module irqc_sequencer
    import irqc_pkg::*;
#(
    parameter int unsigned LINES = IRQ_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] pending_i,
    input  logic             mask_we_i,
    input  logic [LINES-1:0] mask_wdata_i,
    input  logic             core_ready_i,
    input  logic             ret_i,
    output logic             take_o,
    output logic [LINES-1:0] cause_o,
    output logic             active_o
);

    seq_state_e       state_q;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] eligible;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_we_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    assign eligible = pending_i & ~mask_q;
    assign take_o   = (state_q == SEQ_IDLE) && core_ready_i && (eligible != '0);
    assign cause_o  = eligible;
    assign active_o = (state_q == SEQ_HANDLER);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE:    if (take_o) state_q <= SEQ_HANDLER;
                SEQ_HANDLER: if (ret_i)  state_q <= SEQ_IDLE;
                default:                 state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R4: an entry needs the core to be ready
    assert_take_needs_ready_R4: assert property (@(posedge clk) disable iff (rst)
        take_o |-> core_ready_i);

    // R4: an entry always leads into handler mode
    assert_take_enters_R4: assert property (@(posedge clk) disable iff (rst)
        take_o |=> active_o);

    // R8: no nested entry
    assert_no_nest_R8: assert property (@(posedge clk) disable iff (rst)
        active_o |-> !take_o);

    // R9: return ends handler mode
    assert_ret_exits_R9: assert property (@(posedge clk) disable iff (rst)
        (active_o && ret_i) |=> !active_o);

    // R9: handler mode only begins through an entry
    assert_idle_stays_R9: assert property (@(posedge clk) disable iff (rst)
        (!active_o && !take_o) |=> !active_o);

endmodule

// File: rtl/irqc_hregs.sv
module irqc_hregs
    import irqc_pkg::*;
#(
    parameter int unsigned W     = XLEN,
    parameter int unsigned COUNT = HREG_COUNT,
    localparam int unsigned IDX_W = $clog2(COUNT)
) (
    input  logic             clk,
    input  logic             rst,
    input  entry_t           entry_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [W-1:0]     wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [W-1:0]     rd_data_o
);

    logic [W-1:0] regs_q [COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < COUNT; k++) regs_q[k] <= '0;
        end else begin
            for (int k = 0; k < COUNT; k++) begin
                if (entry_i.fire && k == int'(HR_RETADDR)) begin
                    regs_q[k] <= W'(entry_i.ret_pc);
                end else if (entry_i.fire && k == int'(HR_CAUSE)) begin
                    regs_q[k] <= W'(entry_i.cause);
                end else if (wr_en_i && int'(wr_idx_i) == k) begin
                    regs_q[k] <= wr_data_i;
                end
            end
        end
    end

    assign rd_data_o = regs_q[rd_idx_i];

    // R5: return address taken from the core at entry
    assert_capture_pc_R5: assert property (@(posedge clk) disable iff (rst)
        entry_i.fire |=> (regs_q[HR_RETADDR] == W'($past(entry_i.ret_pc))));

    // R6: serviced mask captured and never empty
    assert_capture_cause_R6: assert property (@(posedge clk) disable iff (rst)
        entry_i.fire |=> (regs_q[HR_CAUSE] == W'($past(entry_i.cause))) && (regs_q[HR_CAUSE] != '0));

    // R10: scratch registers keep what the core wrote
    assert_scratch_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i >= IDX_W'(HR_SCRATCH0)) |=>
            (regs_q[$past(wr_idx_i)] == $past(wr_data_i)));

endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irqc_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IRQ_LINES-1:0]  ext_irq,
    input  logic                  evt_timer,
    input  logic                  evt_fault,
    input  logic                  evt_misalign,
    input  logic [XLEN-1:0]       core_pc,
    input  logic                  core_ready,
    input  logic                  handler_ret,
    input  logic                  mask_we,
    input  logic [IRQ_LINES-1:0]  mask_wdata,
    input  logic                  hreg_we,
    input  logic [HREG_IDX_W-1:0] hreg_widx,
    input  logic [XLEN-1:0]       hreg_wdata,
    input  logic [HREG_IDX_W-1:0] hreg_ridx,
    output logic [XLEN-1:0]       hreg_rdata,
    output logic                  irq_take,
    output logic                  in_handler
);

    generate
        if (ENABLE) begin : g_ctrl
            int_evt_t             events;
            logic [IRQ_LINES-1:0] requests;
            logic [IRQ_LINES-1:0] pending;
            logic [IRQ_LINES-1:0] cause;
            logic                 take;
            entry_t               entry;

            assign events   = '{timer: evt_timer, fault: evt_fault, misalign: evt_misalign};
            assign requests = merge_requests(ext_irq, events);

            irqc_pending #(.LINES(IRQ_LINES)) u_pending (
                .clk       (clk),
                .rst       (rst),
                .req_i     (requests),
                .clr_i     (take ? cause : '0),
                .pending_o (pending)
            );

            irqc_sequencer #(.LINES(IRQ_LINES)) u_seq (
                .clk          (clk),
                .rst          (rst),
                .pending_i    (pending),
                .mask_we_i    (mask_we),
                .mask_wdata_i (mask_wdata),
                .core_ready_i (core_ready),
                .ret_i        (handler_ret),
                .take_o       (take),
                .cause_o      (cause),
                .active_o     (in_handler)
            );

            assign entry = '{fire: take, ret_pc: core_pc, cause: cause};

            irqc_hregs #(.W(XLEN), .COUNT(HREG_COUNT)) u_hregs (
                .clk       (clk),
                .rst       (rst),
                .entry_i   (entry),
                .wr_en_i   (hreg_we),
                .wr_idx_i  (hreg_widx),
                .wr_data_i (hreg_wdata),
                .rd_idx_i  (hreg_ridx),
                .rd_data_o (hreg_rdata)
            );

            assign irq_take = take;

            // R6 and R7: a taken line is not pending after the entry edge unless re-requested
            assert_cleared_R7: assert property (@(posedge clk) disable iff (rst)
                take |=> ((pending & $past(cause) & ~$past(requests)) == '0));
        end else begin : g_none
            assign irq_take   = 1'b0;
            assign in_handler = 1'b0;
            assign hreg_rdata = '0;
        end
    endgenerate

endmodule

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
    import irqc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ext_irq = '0;
    logic        evt_timer = 1'b0, evt_fault = 1'b0, evt_misalign = 1'b0;
    logic [31:0] core_pc = '0;
    logic        core_ready = 1'b0, handler_ret = 1'b0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        hreg_we = 1'b0;
    logic [1:0]  hreg_widx = '0, hreg_ridx = '0;
    logic [31:0] hreg_wdata = '0;
    logic [31:0] hreg_rdata, off_rdata;
    logic        irq_take, in_handler, off_take, off_hand;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [31:0] m_pend, m_mask;
    logic        m_act;
    logic [31:0] m_h [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_collector u_irq_collector (
        .clk, .rst, .ext_irq, .evt_timer, .evt_fault, .evt_misalign, .core_pc,
        .core_ready, .handler_ret, .mask_we, .mask_wdata, .hreg_we, .hreg_widx,
        .hreg_wdata, .hreg_ridx, .hreg_rdata, .irq_take, .in_handler
    );

    irq_collector #(.ENABLE(1'b0)) u_off (
        .clk, .rst, .ext_irq, .evt_timer, .evt_fault, .evt_misalign, .core_pc,
        .core_ready, .handler_ret, .mask_we, .mask_wdata, .hreg_we, .hreg_widx,
        .hreg_wdata, .hreg_ridx, .hreg_rdata(off_rdata), .irq_take(off_take),
        .in_handler(off_hand)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] req_vec();
        logic [31:0] r;
        r = ext_irq;
        r[0] = r[0] | evt_timer;
        r[1] = r[1] | evt_fault;
        r[2] = r[2] | evt_misalign;
        return r;
    endfunction

    function automatic logic exp_take();
        return !m_act && core_ready && ((m_pend & ~m_mask) != 0);
    endfunction

    task automatic model_reset();
        m_pend = '0; m_mask = '1; m_act = 1'b0;
        for (int k = 0; k < 4; k++) m_h[k] = '0;
    endtask

    task automatic model_edge();
        logic [31:0] elig, rq;
        logic tk;
        rq   = req_vec();
        elig = m_pend & ~m_mask;
        tk   = exp_take();
        if (hreg_we && !(tk && hreg_widx < 2)) m_h[hreg_widx] = hreg_wdata;
        if (tk) begin
            m_h[0] = core_pc;
            m_h[1] = elig;
            m_pend = (m_pend & ~elig) | rq;
            m_act  = 1'b1;
        end else begin
            m_pend = m_pend | rq;
            if (m_act && handler_ret) m_act = 1'b0;
        end
        if (mask_we) m_mask = mask_wdata;
    endtask

    // Called at a falling edge with inputs set; checks, then crosses one rising edge.
    task automatic step();
        #2;
        chk("R4 take", {31'b0, irq_take}, {31'b0, exp_take()});
        chk("R9 handler", {31'b0, in_handler}, {31'b0, m_act});
        chk("R11 read", hreg_rdata, m_h[hreg_ridx]);
        chk("R13 off take", {31'b0, off_take}, 32'd0);
        chk("R13 off handler", {31'b0, off_hand}, 32'd0);
        chk("R13 off read", off_rdata, 32'd0);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        for (int i = 0; i < 4; i++) begin
            hreg_ridx = 2'(i);
            #1;
            chk("R12 reg zero", hreg_rdata, 32'd0);
            chk("R12 not in handler", {31'b0, in_handler}, 32'd0);
            step();
        end

        // Fault event pulsed once while every line is masked
        core_ready = 1'b1;
        evt_fault  = 1'b1;
        step();
        evt_fault = 1'b0;
        #1;
        chk("R3 reset mask blocks", {31'b0, irq_take}, 32'd0);
        step();
        mask_we = 1'b1; mask_wdata = ~32'h2;
        step();
        mask_we = 1'b0;
        ext_irq = 32'h2;              // line 1 asserted again in the entry cycle
        core_pc = 32'h0000_1000;
        #1;
        chk("R1 fault on line 1", {31'b0, irq_take}, 32'd1);
        chk("R2 sticky", {31'b0, irq_take}, 32'd1);
        step();
        ext_irq = '0;
        hreg_ridx = 2'd1;
        #1;
        chk("R6 cause mask", hreg_rdata, 32'h2);
        chk("R8 no nested take", {31'b0, irq_take}, 32'd0);
        chk("R8 in handler", {31'b0, in_handler}, 32'd1);
        step();
        hreg_ridx = 2'd0;
        #1;
        chk("R5 return address", hreg_rdata, 32'h0000_1000);
        step();
        handler_ret = 1'b1;
        step();
        handler_ret = 1'b0;
        core_pc = 32'h0000_2000;
        #1;
        chk("R9 left handler", {31'b0, in_handler}, 32'd0);
        chk("R7 re-request kept", {31'b0, irq_take}, 32'd1);
        step();
        hreg_ridx = 2'd1;
        hreg_we = 1'b1; hreg_widx = 2'd2; hreg_wdata = 32'hDEAD_BEEF;
        #1;
        chk("R7 second cause", hreg_rdata, 32'h2);
        step();
        hreg_we = 1'b0;
        hreg_ridx = 2'd2;
        handler_ret = 1'b1;
        mask_we = 1'b1; mask_wdata = 32'h0;
        #1;
        chk("R10 scratch", hreg_rdata, 32'hDEAD_BEEF);
        step();
        handler_ret = 1'b0; mask_we = 1'b0;
        evt_misalign = 1'b1;
        step();
        evt_misalign = 1'b0;
        hreg_we = 1'b1; hreg_widx = 2'd0; hreg_wdata = 32'h5555_5555;
        core_pc = 32'h0000_3000;
        #1;
        chk("R4 entry on misalign", {31'b0, irq_take}, 32'd1);
        step();
        hreg_we = 1'b0;
        hreg_ridx = 2'd0;
        #1;
        chk("R10 capture wins", hreg_rdata, 32'h0000_3000);
        step();
        hreg_ridx = 2'd1;
        handler_ret = 1'b1;
        #1;
        chk("R1 misalign on line 2", hreg_rdata, 32'h4);
        step();
        handler_ret = 1'b0;
        // Return outside handler mode with nothing pending: no effect
        handler_ret = 1'b1;
        step();
        handler_ret = 1'b0;
        #1;
        chk("R9 stray return", {31'b0, in_handler}, 32'd0);
        step();

        // Constrained random phase
        for (int c = 0; c < RAND_CYCLES; c++) begin
            ext_irq      = $urandom & $urandom & $urandom & $urandom;
            evt_timer    = ($urandom % 16) == 0;
            evt_fault    = ($urandom % 32) == 0;
            evt_misalign = ($urandom % 32) == 0;
            core_pc      = $urandom;
            core_ready   = ($urandom % 4) != 0;
            handler_ret  = m_act ? (($urandom % 5) == 0) : (($urandom % 30) == 0);
            mask_we      = ($urandom % 20) == 0;
            mask_wdata   = $urandom | $urandom;
            hreg_we      = ($urandom % 8) == 0;
            hreg_widx    = 2'($urandom);
            hreg_wdata   = $urandom;
            hreg_ridx    = 2'($urandom);
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule